// File: doc/BRIEF.md
# DDR Command Spacing Monitor

This block watches the command bus of a DDR SDRAM device and checks every command without ever driving it. Each cycle it decodes the clock-enable, chip-select and strobe lines into a command, then compares the cycles elapsed since earlier relevant commands against minimum spacings. Those spacings are given as parameters counted in clock cycles. Some spacings apply to one bank, such as activate to column access, activate to precharge and precharge to activate. Others span banks, such as activate to activate on different banks and the turnaround from write data to read. The write recovery that an auto-precharge adds is carried forward into the next activate of that bank.

Every rule drives its own flag. The flag pulses for one cycle, in the cycle that follows the offending command. An error vector keeps every flag that has ever fired, and only reset clears it. The monitor is meant for simulation benches and for on-chip debug next to a memory controller. Its limits come from the device clock period: for example, 3 cycles for an 18 ns spacing at a 6 ns clock.

Top module: `ddr_cmd_timing_mon`

## Requirements
- R1: A command is decoded only when cke is 1 and cs_n is 0. The encoding on {ras_n,cas_n,we_n} is 011 activate, 101 read, 100 write and 010 precharge. Every other code, a deselected cycle and a cycle with cke at 0 leave all timing state unchanged.
- R2: Flag bit 0 fires on a read or write to an open bank fewer than T_RCD cycles after that bank's activate.
- R3: Flag bit 1 fires on a precharge of an open bank fewer than T_RAS cycles after its activate. Flag bit 2 pulses once when a bank is still open T_RAS_MAX cycles after its activate and that cycle carries no command that closes it.
- R4: Flag bit 3 fires on an activate fewer than T_RC cycles after the previous activate of the same bank. Flag bit 4 fires on an activate fewer than T_RRD cycles after an activate to a different bank.
- R5: Flag bit 5 fires on an activate fewer than T_RP cycles after a precharge of that bank.
- R6: Flag bit 6 fires on a precharge of an open bank issued fewer than T_WR cycles after the last write data of that bank. The last data of a write lands BL/2 cycles after the write command.
- R7: Flag bit 7 fires on a read issued fewer than T_WTR cycles after the last write data of any bank. Reads issued back to back one cycle apart raise no flag.
- R8: Flag bit 8 fires on an activate that comes too soon after an auto-precharge on that bank. After a write with a10 at 1, the activate must come at least BL/2+T_WR+T_RP cycles later. After a read with a10 at 1, it must come at least BL/2+T_RP cycles later.
- R9: Flag bit 9 fires on a read or write to any bank issued fewer than BL/2 cycles after a write with auto-precharge.
- R10: Flags are registered, so each one is high for exactly the cycle after the offending command. Each bit of err_o stays set from the cycle its flag first rises, and only reset clears it.
- R11: ba selects bank 0 to 3 as a binary number. A precharge with a10 at 1 applies to all banks whatever the value of ba.
- R12: bl_sel sets the burst length and is sampled with each write: 00 gives BL2, 01 gives BL4, and 10 or 11 give BL8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable sampled with the command |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank number |
| a10 | input | 1 | Auto-precharge on column commands, all-bank select on precharge |
| bl_sel | input | 2 | Burst length code |
| viol_o | output | 10 | One-cycle flag per rule |
| err_o | output | 10 | Sticky record of the flags |

## Verification
Some properties are checked on every cycle. The error vector never loses a bit and always covers the current flags. A cycle with cke at 0 decodes to no command. At most one bank accepts a given activate. Every elapsed-cycle counter restarts at one and never wraps. The open-too-long flag never fires on two cycles in a row. The actual spacing limits, where each boundary sits and how burst length shifts the write-related limits can only be shown by the bench. It sweeps each command spacing across its threshold for every burst code and computes the expected flag vector from the limits.

// File: rtl/ddr_mon_pkg.sv
package ddr_mon_pkg;

   typedef enum logic [2:0] {
      CMD_NOP,
      CMD_ACT,
      CMD_RD,
      CMD_WR,
      CMD_PRE,
      CMD_REF,
      CMD_MRS
   } cmd_e;

   localparam int NUM_RULES   = 10;
   localparam int RULE_RCD    = 0;
   localparam int RULE_RAS    = 1;
   localparam int RULE_RASMAX = 2;
   localparam int RULE_RC     = 3;
   localparam int RULE_RRD    = 4;
   localparam int RULE_RP     = 5;
   localparam int RULE_WR     = 6;
   localparam int RULE_WTR    = 7;
   localparam int RULE_APACT  = 8;
   localparam int RULE_INTR   = 9;

   // half the burst length: cycles from a write to its last data beat
   function automatic logic [2:0] burst_half(input logic [1:0] sel);
      case (sel)
         2'b00:   return 3'd1;
         2'b01:   return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
   import ddr_mon_pkg::*;
(
   input  logic cke,
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd
);

   always_comb begin
      cmd = CMD_NOP;
      if (cke && !cs_n) begin
         case ({ras_n, cas_n, we_n})
            3'b011:  cmd = CMD_ACT;
            3'b101:  cmd = CMD_RD;
            3'b100:  cmd = CMD_WR;
            3'b010:  cmd = CMD_PRE;
            3'b001:  cmd = CMD_REF;
            3'b000:  cmd = CMD_MRS;
            default: cmd = CMD_NOP;
         endcase
      end
   end

endmodule

// File: rtl/ddr_since_ctr.sv
module ddr_since_ctr #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         hit,
   output logic [W-1:0] cnt,
   output logic         seen
);

   localparam logic [W-1:0] CNT_TOP = {W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         seen <= 1'b0;
      end else if (hit) begin
         cnt  <= W'(1);
         seen <= 1'b1;
      end else if (cnt != CNT_TOP) begin
         cnt <= cnt + W'(1);
      end
   end

   // R4: spacing measured from an event starts at one cycle
   p_ctr_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> (cnt == W'(1) && seen));

   // R4: the elapsed count saturates instead of wrapping
   p_ctr_nowrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && cnt != '0) |=> (cnt != '0));

endmodule

// File: rtl/ddr_bank_track.sv
module ddr_bank_track
   import ddr_mon_pkg::*;
#(
   parameter int CW             = 8,
   parameter int T_RCD          = 3,
   parameter int T_RAS          = 7,
   parameter int T_RAS_MAX      = 100,
   parameter int T_RC           = 10,
   parameter int T_RP           = 3,
   parameter int T_WR           = 3,
   parameter bit CHECK_OPEN_MAX = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  cmd_e                 cmd,
   input  logic                 sel,
   input  logic                 a10,
   input  logic [2:0]           half,
   output logic [NUM_RULES-1:0] viol
);

   localparam logic [CW-1:0] L_RCD  = CW'(T_RCD);
   localparam logic [CW-1:0] L_RAS  = CW'(T_RAS);
   localparam logic [CW-1:0] L_RMAX = CW'(T_RAS_MAX);
   localparam logic [CW-1:0] L_RC   = CW'(T_RC);
   localparam logic [CW-1:0] L_RP   = CW'(T_RP);
   localparam logic [CW-1:0] L_WR   = CW'(T_WR);

   logic is_act, is_rd, is_wr, is_pre, is_col, is_ap, closing;
   logic [CW-1:0] act_cnt, pre_cnt, wr_cnt, ap_cnt;
   logic act_seen, pre_seen, wr_seen, ap_seen;
   logic open_q;
   logic [CW-1:0] wlen_q, ap_need_q;
   logic open_too_long;

   assign is_act  = sel && (cmd == CMD_ACT);
   assign is_rd   = sel && (cmd == CMD_RD);
   assign is_wr   = sel && (cmd == CMD_WR);
   assign is_pre  = sel && (cmd == CMD_PRE);
   assign is_col  = is_rd || is_wr;
   assign is_ap   = is_col && a10;
   assign closing = is_pre || is_ap;

   ddr_since_ctr #(.W(CW)) u_act (.clk(clk), .rst_n(rst_n), .hit(is_act), .cnt(act_cnt), .seen(act_seen));
   ddr_since_ctr #(.W(CW)) u_pre (.clk(clk), .rst_n(rst_n), .hit(is_pre), .cnt(pre_cnt), .seen(pre_seen));
   ddr_since_ctr #(.W(CW)) u_wr  (.clk(clk), .rst_n(rst_n), .hit(is_wr),  .cnt(wr_cnt),  .seen(wr_seen));
   ddr_since_ctr #(.W(CW)) u_ap  (.clk(clk), .rst_n(rst_n), .hit(is_ap),  .cnt(ap_cnt),  .seen(ap_seen));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q    <= 1'b0;
         wlen_q    <= '0;
         ap_need_q <= '0;
      end else begin
         if (is_act)       open_q <= 1'b1;
         else if (closing) open_q <= 1'b0;
         if (is_wr) wlen_q <= CW'(half);
         if (is_ap) ap_need_q <= CW'(half) + (is_wr ? L_WR : '0) + L_RP;
      end
   end

   generate
      if (CHECK_OPEN_MAX) begin : g_open_max
         assign open_too_long = open_q && !closing && !is_act && (act_cnt == L_RMAX);
      end else begin : g_no_open_max
         assign open_too_long = 1'b0;
      end
   endgenerate

   always_comb begin
      viol              = '0;
      viol[RULE_RCD]    = is_col && open_q && (act_cnt < L_RCD);
      viol[RULE_RAS]    = is_pre && open_q && (act_cnt < L_RAS);
      viol[RULE_RASMAX] = open_too_long;
      viol[RULE_RC]     = is_act && act_seen && (act_cnt < L_RC);
      viol[RULE_RP]     = is_act && pre_seen && (pre_cnt < L_RP);
      viol[RULE_WR]     = is_pre && open_q && wr_seen && (wr_cnt < wlen_q + L_WR);
      viol[RULE_APACT]  = is_act && ap_seen && (ap_cnt < ap_need_q);
   end

   // R2: an activate leaves the bank open in the next cycle
   p_open_after_act_r2: assert property (@(posedge clk) disable iff (!rst_n)
      is_act |=> open_q);

   // R3: the open-too-long flag is a single-cycle event
   p_rasmax_once_r3: assert property (@(posedge clk) disable iff (!rst_n)
      viol[RULE_RASMAX] |=> !viol[RULE_RASMAX]);

endmodule

// File: rtl/ddr_cmd_timing_mon.sv
module ddr_cmd_timing_mon
   import ddr_mon_pkg::*;
#(
   parameter int BA_W           = 2,
   parameter int T_RCD          = 3,
   parameter int T_RAS          = 7,
   parameter int T_RAS_MAX      = 11667,
   parameter int T_RC           = 10,
   parameter int T_RRD          = 2,
   parameter int T_RP           = 3,
   parameter int T_WR           = 3,
   parameter int T_WTR          = 1,
   parameter bit CHECK_OPEN_MAX = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cke,
   input  logic                 cs_n,
   input  logic                 ras_n,
   input  logic                 cas_n,
   input  logic                 we_n,
   input  logic [BA_W-1:0]      ba,
   input  logic                 a10,
   input  logic [1:0]           bl_sel,
   output logic [NUM_RULES-1:0] viol_o,
   output logic [NUM_RULES-1:0] err_o
);

   localparam int NB = 1 << BA_W;
   localparam int CW = $clog2(T_RAS_MAX + 2) + 1;
   localparam logic [CW-1:0] L_RRD = CW'(T_RRD);
   localparam logic [CW-1:0] L_WTR = CW'(T_WTR);

   generate
      if (BA_W < 1) begin : g_bad_ba
         $error("BA_W must be at least 1");
      end
      if (T_RCD < 1 || T_RP < 1 || T_RRD < 1 || T_WTR < 1) begin : g_bad_min
         $error("spacing limits must be at least one cycle");
      end
      if (T_RC < T_RAS) begin : g_bad_rc
         $error("T_RC must not be below T_RAS");
      end
      if (T_RAS_MAX <= T_RC + T_WR + T_RP + T_WTR + 4) begin : g_bad_max
         $error("T_RAS_MAX too small for the counter sizing");
      end
   endgenerate

   cmd_e dec_cmd;
   logic [2:0] half;
   logic [NB-1:0] bank_sel;
   logic [NUM_RULES-1:0] bank_viol [NB];
   logic [NUM_RULES-1:0] viol_next;

   ddr_cmd_decode u_dec (
      .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(dec_cmd)
   );

   assign half = burst_half(bl_sel);

   generate
      for (genvar g = 0; g < NB; g++) begin : g_bank
         assign bank_sel[g] = (ba == BA_W'(g)) || ((dec_cmd == CMD_PRE) && a10);
         ddr_bank_track #(
            .CW(CW), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RAS_MAX(T_RAS_MAX),
            .T_RC(T_RC), .T_RP(T_RP), .T_WR(T_WR), .CHECK_OPEN_MAX(CHECK_OPEN_MAX)
         ) u_trk (
            .clk(clk), .rst_n(rst_n), .cmd(dec_cmd), .sel(bank_sel[g]),
            .a10(a10), .half(half), .viol(bank_viol[g])
         );
      end
   endgenerate

   // cross-bank history
   logic gact_hit, gwr_hit, gwap_hit;
   logic [CW-1:0] gact_cnt, gwr_cnt, gwap_cnt;
   logic gact_seen, gwr_seen, gwap_seen;
   logic [BA_W-1:0] last_ba_q;
   logic [CW-1:0] gwlen_q, gwaplen_q;

   assign gact_hit = (dec_cmd == CMD_ACT);
   assign gwr_hit  = (dec_cmd == CMD_WR);
   assign gwap_hit = gwr_hit && a10;

   ddr_since_ctr #(.W(CW)) u_gact (.clk(clk), .rst_n(rst_n), .hit(gact_hit), .cnt(gact_cnt), .seen(gact_seen));
   ddr_since_ctr #(.W(CW)) u_gwr  (.clk(clk), .rst_n(rst_n), .hit(gwr_hit),  .cnt(gwr_cnt),  .seen(gwr_seen));
   ddr_since_ctr #(.W(CW)) u_gwap (.clk(clk), .rst_n(rst_n), .hit(gwap_hit), .cnt(gwap_cnt), .seen(gwap_seen));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_ba_q <= '0;
         gwlen_q   <= '0;
         gwaplen_q <= '0;
      end else begin
         if (gact_hit) last_ba_q <= ba;
         if (gwr_hit)  gwlen_q   <= CW'(half);
         if (gwap_hit) gwaplen_q <= CW'(half);
      end
   end

   always_comb begin
      viol_next = '0;
      for (int b = 0; b < NB; b++) viol_next = viol_next | bank_viol[b];
      viol_next[RULE_RRD]  = gact_hit && gact_seen && (last_ba_q != ba) && (gact_cnt < L_RRD);
      viol_next[RULE_WTR]  = (dec_cmd == CMD_RD) && gwr_seen && (gwr_cnt < gwlen_q + L_WTR);
      viol_next[RULE_INTR] = ((dec_cmd == CMD_RD) || (dec_cmd == CMD_WR)) && gwap_seen
                             && (gwap_cnt < gwaplen_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         viol_o <= '0;
         err_o  <= '0;
      end else begin
         viol_o <= viol_next;
         err_o  <= err_o | viol_next;
      end
   end

   // R1: a cycle with clock enable low carries no command
   p_cke_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !cke |-> (dec_cmd == CMD_NOP));

   // R11: an activate reaches at most one bank
   p_onehot_act_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(bank_sel & {NB{gact_hit}}));

   // R10: recorded errors are never lost
   p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((err_o & $past(err_o)) == $past(err_o)));

   // R10: every live flag is already recorded
   p_err_covers_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (viol_o != '0) |-> ((err_o & viol_o) == viol_o));

endmodule

// File: tb/ddr_cmd_timing_mon_test.sv
module ddr_cmd_timing_mon_test;
   import ddr_mon_pkg::*;

   localparam int T_RCD = 3, T_RAS = 6, T_RAS_MAX = 30, T_RC = 9;
   localparam int T_RRD = 2, T_RP = 3, T_WR = 2, T_WTR = 1;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n, cke, cs_n, ras_n, cas_n, we_n, a10;
   logic [1:0] ba, bl_sel;
   logic [NUM_RULES-1:0] viol_o, err_o, last_v;

   int checks = 0, fails = 0;
   bit done = 1'b0;

   ddr_cmd_timing_mon #(
      .BA_W(2), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RAS_MAX(T_RAS_MAX), .T_RC(T_RC),
      .T_RRD(T_RRD), .T_RP(T_RP), .T_WR(T_WR), .T_WTR(T_WTR), .CHECK_OPEN_MAX(1'b1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .ba(ba), .a10(a10), .bl_sel(bl_sel), .viol_o(viol_o), .err_o(err_o)
   );

   function automatic logic [NUM_RULES-1:0] m(input int idx);
      return NUM_RULES'(1) << idx;
   endfunction

   function automatic int half_of(input int code);
      return (code == 0) ? 1 : (code == 1) ? 2 : 4;
   endfunction

   task automatic check(input string req, input logic [NUM_RULES-1:0] got,
                        input logic [NUM_RULES-1:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%b expected=%b", req, got, exp);
      end
   endtask

   task automatic drive(input logic k, input logic cs, input logic [2:0] rcw,
                        input logic [1:0] b, input logic ap);
      cke = k; cs_n = cs; {ras_n, cas_n, we_n} = rcw; ba = b; a10 = ap;
      @(negedge clk);
      last_v = viol_o;
      cke = 1'b1; cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111; a10 = 1'b0;
   endtask

   task automatic act(input logic [1:0] b);                 drive(1, 0, 3'b011, b, 0);  endtask
   task automatic rd(input logic [1:0] b, input logic ap);  drive(1, 0, 3'b101, b, ap); endtask
   task automatic wr(input logic [1:0] b, input logic ap);  drive(1, 0, 3'b100, b, ap); endtask
   task automatic pre(input logic [1:0] b, input logic al); drive(1, 0, 3'b010, b, al); endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         last_v = viol_o;
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(8 * 100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      rst_n = 1'b0; cke = 1'b1; cs_n = 1'b1; {ras_n, cas_n, we_n} = 3'b111;
      ba = 2'd0; a10 = 1'b0; bl_sel = 2'b01; last_v = '0;
      do_reset();
      check("R10 reset flags", viol_o, '0);
      check("R10 reset errors", err_o, '0);

      // R2: activate to column spacing, read and write
      for (int d = 1; d <= T_RCD + 1; d++) begin
         do_reset(); act(2); idle(d - 1); rd(2, 0);
         check("R2 act-read", last_v, (d < T_RCD) ? m(RULE_RCD) : '0);
         do_reset(); act(2); idle(d - 1); wr(2, 0);
         check("R2 act-write", last_v, (d < T_RCD) ? m(RULE_RCD) : '0);
      end

      // R3: activate to precharge minimum
      for (int d = 1; d <= T_RAS + 1; d++) begin
         do_reset(); act(1); idle(d - 1); pre(1, 0);
         check("R3 act-pre", last_v, (d < T_RAS) ? m(RULE_RAS) : '0);
      end

      // R3: open too long fires once
      do_reset(); act(0);
      for (int k = 1; k <= T_RAS_MAX + 3; k++) begin
         idle(1);
         check("R3 open max", last_v, (k == T_RAS_MAX) ? m(RULE_RASMAX) : '0);
      end
      do_reset(); act(0); idle(T_RAS_MAX - 1); pre(0, 0);
      check("R3 close at limit", last_v, '0);
      idle(3);
      check("R3 no late flag", err_o, '0);

      // R4: same bank and different bank activates
      for (int d = 1; d <= T_RC + 1; d++) begin
         do_reset(); act(3); idle(d - 1); act(3);
         check("R4 act-act same", last_v, (d < T_RC) ? m(RULE_RC) : '0);
      end
      for (int d = 1; d <= T_RRD + 1; d++) begin
         do_reset(); act(0); idle(d - 1); act(1);
         check("R4 act-act other", last_v, (d < T_RRD) ? m(RULE_RRD) : '0);
      end

      // R5: precharge to activate; R11 precharge-all from another ba
      for (int d = 1; d <= T_RP + 1; d++) begin
         do_reset(); act(1); idle(T_RC); pre(1, 0); idle(d - 1); act(1);
         check("R5 pre-act", last_v, (d < T_RP) ? m(RULE_RP) : '0);
         do_reset(); act(1); idle(T_RC); pre(2, 1); idle(d - 1); act(1);
         check("R11 pre-all reaches bank", last_v, (d < T_RP) ? m(RULE_RP) : '0);
      end
      do_reset(); act(1); idle(T_RC); pre(2, 0); act(1);
      check("R11 pre other bank ignored", last_v, '0);

      // R6 and R12: write recovery for every burst code
      for (int c = 0; c < 4; c++) begin
         bl_sel = 2'(c);
         for (int d = 1; d <= half_of(c) + T_WR + 1; d++) begin
            logic [NUM_RULES-1:0] e;
            e = '0;
            if (d < half_of(c) + T_WR) e |= m(RULE_WR);
            if (T_RCD + d < T_RAS) e |= m(RULE_RAS);
            do_reset(); act(0); idle(T_RCD - 1); wr(0, 0); idle(d - 1); pre(0, 0);
            check("R6 R12 write-pre", last_v, e);
         end
      end

      // R7: write to read turnaround
      for (int c = 0; c < 3; c++) begin
         bl_sel = 2'(c);
         for (int d = 1; d <= half_of(c) + T_WTR + 1; d++) begin
            do_reset(); act(0); idle(T_RCD - 1); wr(0, 0); idle(d - 1); rd(0, 0);
            check("R7 write-read", last_v, (d < half_of(c) + T_WTR) ? m(RULE_WTR) : '0);
         end
      end
      do_reset(); act(0); idle(T_RCD - 1); rd(0, 0); rd(0, 0);
      check("R7 read back to back", last_v, '0);

      // R8: auto-precharge write and read to next activate
      for (int c = 0; c < 3; c++) begin
         bl_sel = 2'(c);
         for (int d = 1; d <= half_of(c) + T_WR + T_RP + 1; d++) begin
            logic [NUM_RULES-1:0] e;
            e = (d < half_of(c) + T_WR + T_RP) ? m(RULE_APACT) : '0;
            if (T_RCD + d < T_RC) e |= m(RULE_RC);
            do_reset(); act(2); idle(T_RCD - 1); wr(2, 1); idle(d - 1); act(2);
            check("R8 write-ap act", last_v, e);
         end
         for (int d = 1; d <= half_of(c) + T_RP + 1; d++) begin
            logic [NUM_RULES-1:0] e;
            e = (d < half_of(c) + T_RP) ? m(RULE_APACT) : '0;
            if (T_RCD + d < T_RC) e |= m(RULE_RC);
            do_reset(); act(2); idle(T_RCD - 1); rd(2, 1); idle(d - 1); act(2);
            check("R8 read-ap act", last_v, e);
         end
      end

      // R9: column command inside a write burst with auto-precharge
      for (int c = 0; c < 3; c++) begin
         bl_sel = 2'(c);
         for (int d = 1; d <= half_of(c) + 1; d++) begin
            do_reset(); act(0); idle(T_RRD - 1); act(1); idle(T_RCD); wr(0, 1); idle(d - 1); wr(1, 0);
            check("R9 write-ap interrupt", last_v, (d < half_of(c)) ? m(RULE_INTR) : '0);
         end
      end
      bl_sel = 2'b01;
      do_reset(); act(0); idle(T_RRD - 1); act(1); idle(T_RCD); wr(0, 1); rd(1, 0);
      check("R9 read interrupt", last_v, m(RULE_INTR) | m(RULE_WTR));

      // R1: deselect, cke low, refresh and mode set leave timing alone
      do_reset(); act(0);
      drive(1, 1, 3'b011, 2'd0, 0);
      check("R1 deselect", last_v, '0);
      drive(0, 0, 3'b011, 2'd0, 0);
      check("R1 cke low", last_v, '0);
      drive(1, 0, 3'b001, 2'd0, 0);
      drive(1, 0, 3'b000, 2'd0, 0);
      check("R1 refresh/mode", last_v, '0);
      act(0);
      check("R1 timing kept from first act", last_v, m(RULE_RC));

      // R10: pulse width and sticky record
      do_reset(); act(0); act(0);
      check("R10 flag pulse", last_v, m(RULE_RC));
      idle(1);
      check("R10 flag drops", last_v, '0);
      check("R10 error held", err_o, m(RULE_RC));
      pre(0, 0);
      idle(5);
      check("R10 error union", err_o, m(RULE_RC) | m(RULE_RAS));
      do_reset();
      check("R10 reset clears errors", err_o, '0);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule